// File: doc/BRIEF.md
# Memory-Mapped Flash Read Controller with Sequential Prefetch

This block serves bus reads that fall in a memory-mapped window onto an external quad-SPI flash. It turns each bus address into a flash address by overwriting the top twelve address bits with a programmable remap value. It then fetches words through a simple request/acknowledge word-read engine. Once a 32-bit read has completed, the block treats the following word address as the next expected access. It fills a small prefetch FIFO ahead of the bus, so a run of consecutive 32-bit reads is served from local storage instead of waiting on the flash.

Byte reads, halfword reads and 32-bit reads to any other address leave the FIFO. Each one empties it, stops prefetching and performs one direct flash word read. Only the addressed byte lanes are returned. Whenever a prefetched word lands in the FIFO and DMA is enabled, the block emits a one-cycle DMA request. An external DMA engine can therefore pace itself on ready data, but only after a bus access has started the run.

The controller has three states:
- IDLE: no flash access is in progress.
- PREFETCH: a word read is in flight to fill the FIFO.
- DIRECT: a bypass read is in flight for a pending bus access.

It has four transitions:
- IDLE→DIRECT: a pending non-sequential or narrow read arrives while mapping is on.
- IDLE→PREFETCH: mapping is on, a sequential run is active and the FIFO has space.
- PREFETCH→IDLE: the flash acknowledges the prefetch read.
- DIRECT→IDLE: the flash acknowledges the direct read.

While the block is in PREFETCH or DIRECT, the flash select output is high. Because every access returns through IDLE, the select always drops for at least one cycle between accesses.

Top module: `mmpf_read_ctrl`

## Requirements
- R1: While `map_en` is 0, a pending bus read is answered one cycle after it is seen, with `bus_rdata` equal to zero. No flash access is started.
- R2: Every flash access address equals `{remap_hi, bus_addr[19:2], 2'b00}`, where `bus_addr` is the bus address of the word being fetched.
- R3: A 32-bit read (`bus_size` = 2) at the word following the previous 32-bit read is served from the FIFO. When the FIFO holds data, `bus_ready` rises one cycle after the request is seen, and the returned word equals the flash word at that address.
- R4: After a 32-bit read completes, the block prefetches the following words until the FIFO holds FIFO_DEPTH (4) words, and it never writes a full FIFO.
- R5: A byte read (`bus_size` = 0) or halfword read (`bus_size` = 1) performs exactly one direct flash word read. It returns the byte at lane `bus_addr[1:0]`, or the halfword at lane `bus_addr[1]`, in place, with all other bits zero (little-endian lanes). It stops prefetching.
- R6: A 32-bit read to a non-sequential address empties the FIFO, performs one direct read returning the full word, and then restarts prefetching from the word after it.
- R7: When `dma_en` is 1, `dma_req` pulses for one cycle for each word added to the FIFO. When `dma_en` is 0, and for direct reads, no pulse is produced.
- R8: `fl_cs` is high only while a flash access is in progress. `fl_req` pulses once at the start of each access. `fl_cs` is low in the cycle after each `fl_ack`.
- R9: Clearing `map_en` empties the FIFO. Once any in-flight access has been acknowledged, the block stays idle. After mapping is re-enabled, the next read is a direct read.
- R10: `bus_ready` is a single-cycle pulse, and `bus_rdata` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_en | input | 1 | Memory-mapped read enable |
| dma_en | input | 1 | Enables DMA request pulses |
| remap_hi | input | 12 | Replacement for address bits 31:20 |
| bus_req | input | 1 | Bus read pending; held until `bus_ready` |
| bus_addr | input | 32 | Bus byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_ready | output | 1 | One-cycle read completion |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| fl_req | output | 1 | One-cycle start of a flash word read |
| fl_cs | output | 1 | Flash select, high during an access |
| fl_addr | output | 32 | Flash word address |
| fl_ack | input | 1 | Flash read done, one cycle |
| fl_rdata | input | 32 | Flash word, valid with `fl_ack` |
| dma_req | output | 1 | One-cycle DMA request per prefetched word |

## Verification
The assertions check the following on every cycle:
- the FIFO never overflows or underflows;
- the prefetch address stays exactly as far ahead of the expected bus address as the FIFO fill level;
- the remap value appears on each flash address;
- the select drops after every acknowledge;
- DMA pulses occur only with DMA enabled;
- the completion pulse lasts one cycle.

Only the bench's scenarios can show the rest, because it depends on a flash data model and on sequences of accesses:
- the returned data and byte lanes are correct;
- the FIFO fill count and the number of DMA pulses match each run;
- the hit latency is one cycle;
- the FIFO is emptied, so a read after a disable falls back to a direct read.

// File: rtl/mmpf_pkg.sv
package mmpf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PREF   = 2'd1,
        ST_DIRECT = 2'd2
    } rd_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/mmpf_fifo.sv
module mmpf_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/mmpf_lane.sv
module mmpf_lane #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]             word,
    input  logic [$clog2(DW/8)-1:0]   ofs,
    input  logic [1:0]                size,
    output logic [DW-1:0]             lanes
);
    import mmpf_pkg::*;
    localparam int NL = DW / 8;
    localparam int OW = $clog2(NL);

    for (genvar gi = 0; gi < NL; gi++) begin : g_lane
        localparam logic [OW-1:0] LN = OW'(gi);
        logic keep;
        assign keep = (size == SZ_WORD)
                   || (size == SZ_HALF && ofs[OW-1:1] == LN[OW-1:1])
                   || (size == SZ_BYTE && ofs == LN);
        assign lanes[gi*8 +: 8] = keep ? word[gi*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/mmpf_remap.sv
module mmpf_remap #(
    parameter int ADDR_W  = 32,
    parameter int REMAP_W = 12
) (
    input  logic [REMAP_W-1:0]          remap_hi,
    input  logic [ADDR_W-REMAP_W-3:0]   word_low,
    output logic [ADDR_W-1:0]           flash_addr
);
    assign flash_addr = {remap_hi, word_low, 2'b00};
endmodule

// File: rtl/mmpf_read_ctrl.sv
module mmpf_read_ctrl #(
    parameter int DATA_W     = 32,
    parameter int REMAP_W    = 12,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 map_en,
    input  logic                 dma_en,
    input  logic [REMAP_W-1:0]   remap_hi,
    input  logic                 bus_req,
    input  logic [31:0]          bus_addr,
    input  logic [1:0]           bus_size,
    output logic                 bus_ready,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 fl_req,
    output logic                 fl_cs,
    output logic [31:0]          fl_addr,
    input  logic                 fl_ack,
    input  logic [DATA_W-1:0]    fl_rdata,
    output logic                 dma_req
);
    import mmpf_pkg::*;

    localparam int ADDR_W = 32;
    localparam int WA_W   = ADDR_W - 2;
    localparam int LOW_W  = ADDR_W - REMAP_W - 2;
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

    rd_state_e st, st_nx;

    logic              stream_on;
    logic [WA_W-1:0]   exp_w, pf_w, cur_w;
    logic [1:0]        cur_ofs, cur_size;

    logic [WA_W-1:0]   bus_w;
    logic              acc, hit, miss, in_idle;
    logic              start_direct, start_pref, pop, push, flush;
    logic [LOW_W-1:0]  map_low;
    logic [ADDR_W-1:0] map_addr;
    logic [DATA_W-1:0] f_dout, lane_out;
    logic [CNT_W-1:0]  f_count;
    logic              f_full, f_empty;

    // request decode
    assign bus_w        = bus_addr[ADDR_W-1:2];
    assign acc          = bus_req && !bus_ready;
    assign hit          = acc && (bus_size == SZ_WORD) && stream_on && (bus_w == exp_w);
    assign miss         = acc && !hit;
    assign in_idle      = (st == ST_IDLE);
    assign start_direct = in_idle && map_en && miss;
    assign start_pref   = in_idle && map_en && !miss && stream_on && !f_full;
    assign pop          = in_idle && map_en && hit && !f_empty;
    assign flush        = in_idle && (!map_en || miss);
    assign push         = (st == ST_PREF) && fl_ack && map_en && !miss;
    assign map_low      = start_direct ? bus_w[LOW_W-1:0] : pf_w[LOW_W-1:0];
    assign fl_cs        = (st != ST_IDLE);

    mmpf_fifo #(.DEPTH(FIFO_DEPTH), .DW(DATA_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .din   (fl_rdata),
        .pop   (pop),
        .dout  (f_dout),
        .count (f_count),
        .full  (f_full),
        .empty (f_empty)
    );

    mmpf_remap #(.ADDR_W(ADDR_W), .REMAP_W(REMAP_W)) u_remap (
        .remap_hi   (remap_hi),
        .word_low   (map_low),
        .flash_addr (map_addr)
    );

    mmpf_lane #(.DW(DATA_W)) u_lane (
        .word  (fl_rdata),
        .ofs   (cur_ofs),
        .size  (cur_size),
        .lanes (lane_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (start_direct)    st_nx = ST_DIRECT;
                else if (start_pref) st_nx = ST_PREF;
            end
            ST_PREF:   if (fl_ack) st_nx = ST_IDLE;
            ST_DIRECT: if (fl_ack) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
            fl_req    <= 1'b0;
            fl_addr   <= '0;
            dma_req   <= 1'b0;
            stream_on <= 1'b0;
            exp_w     <= '0;
            pf_w      <= '0;
            cur_w     <= '0;
            cur_ofs   <= '0;
            cur_size  <= '0;
        end else begin
            bus_ready <= 1'b0;
            fl_req    <= 1'b0;
            dma_req   <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (acc && !map_en) begin
                        bus_ready <= 1'b1;
                        bus_rdata <= '0;
                    end
                    if (!map_en || miss) stream_on <= 1'b0;
                    if (start_direct) begin
                        fl_req   <= 1'b1;
                        fl_addr  <= map_addr;
                        cur_w    <= bus_w;
                        cur_ofs  <= bus_addr[1:0];
                        cur_size <= bus_size;
                    end else if (start_pref) begin
                        fl_req  <= 1'b1;
                        fl_addr <= map_addr;
                    end
                    if (pop) begin
                        bus_ready <= 1'b1;
                        bus_rdata <= f_dout;
                        exp_w     <= exp_w + 1'b1;
                    end
                end
                ST_PREF: begin
                    if (push) begin
                        pf_w    <= pf_w + 1'b1;
                        dma_req <= dma_en;
                    end
                end
                ST_DIRECT: begin
                    if (fl_ack && map_en) begin
                        bus_ready <= 1'b1;
                        bus_rdata <= lane_out;
                        if (cur_size == SZ_WORD) begin
                            stream_on <= 1'b1;
                            exp_w     <= cur_w + 1'b1;
                            pf_w      <= cur_w + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assert_remap_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> fl_addr[ADDR_W-1 -: REMAP_W] == $past(remap_hi));
    assert_fill_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stream_on |-> (pf_w - exp_w) == WA_W'(f_count));
    assert_dma_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(dma_en));
    assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ack |=> !fl_cs);
    assert_req_in_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> fl_cs);
    assert_idle_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_cs && !map_en) |=> !fl_cs);
    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

endmodule

// File: tb/test_mmpf_read_ctrl.sv
`timescale 1ns/1ps
module test_mmpf_read_ctrl;
    localparam int LAT = 3;
    localparam logic [11:0] RMP = 12'h3C1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_en = 1'b0, dma_en = 1'b0;
    logic [11:0] remap_hi = RMP;
    logic        bus_req = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_ready, fl_req, fl_cs, dma_req;
    logic [31:0] bus_rdata, fl_addr;
    logic        fl_ack = 1'b0;
    logic [31:0] fl_rdata = '0;

    int checks = 0, errors = 0;
    int nreads = 0, ndma = 0, cs_err = 0, log_n = 0, pend = 0;
    logic [31:0] pend_addr = '0;
    logic [31:0] log_addr [64];

    always #2.5 clk = ~clk;

    mmpf_read_ctrl i_mmpf_read_ctrl (
        .clk(clk), .rst_n(rst_n), .map_en(map_en), .dma_en(dma_en),
        .remap_hi(remap_hi), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .fl_req(fl_req), .fl_cs(fl_cs), .fl_addr(fl_addr), .fl_ack(fl_ack),
        .fl_rdata(fl_rdata), .dma_req(dma_req)
    );

    function automatic logic [31:0] fmodel(input logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] rmp(input logic [31:0] a);
        return {RMP, a[19:2], 2'b00};
    endfunction

    function automatic logic [31:0] exp_lane(input logic [31:0] w, input logic [1:0] o,
                                             input logic [1:0] sz);
        if (sz == 2'd2) return w;
        if (sz == 2'd1) return o[1] ? {w[31:16], 16'h0} : {16'h0, w[15:0]};
        return (w & (32'hFF << (8 * o)));
    endfunction

    // flash model and monitors, all on the falling edge
    always @(negedge clk) begin
        if (fl_ack && fl_cs) cs_err++;
        if (dma_req) ndma++;
        fl_ack = 1'b0;
        if (fl_req) begin
            pend_addr = fl_addr;
            pend = LAT;
            nreads++;
            if (log_n < 64) log_addr[log_n] = fl_addr;
            log_n++;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                fl_ack = 1'b1;
                fl_rdata = fmodel(pend_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bread(input logic [31:0] a, input logic [1:0] sz,
                         output logic [31:0] d, output int cyc);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_req = 1'b1; cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!bus_ready && cyc < 500);
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, a;
        int cyc, n0, d0;
        idle(3);
        // reset state (R8, R10)
        chk(!bus_ready && !fl_cs && !fl_req && !dma_req, "R10 reset outputs",
            {28'h0, bus_ready, fl_cs, fl_req, dma_req}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R1: mapping off
        bread(32'h0000_0100, 2'd2, d, cyc);
        chk(d == 32'h0, "R1 data while disabled", d, 32'h0);
        chk(cyc == 1, "R1 latency while disabled", cyc, 1);
        chk(nreads == 0, "R1 no flash access", nreads, 0);
        @(negedge clk);
        chk(!bus_ready, "R10 ready single pulse", {31'h0, bus_ready}, 0);

        // R2 / R6: direct word read with remap
        map_en = 1'b1;
        n0 = nreads; log_n = 0;
        bread(32'h0ABC_1230, 2'd2, d, cyc);
        chk(log_addr[0] == rmp(32'h0ABC_1230), "R2 flash address", log_addr[0], rmp(32'h0ABC_1230));
        chk(d == fmodel(rmp(32'h0ABC_1230)), "R6 direct word data", d, fmodel(rmp(32'h0ABC_1230)));

        // R4: fill to depth
        idle(40);
        chk(nreads - n0 == 5, "R4 prefetch fills four words", nreads - n0, 5);

        // R3: sequential run from the FIFO
        bread(32'h0ABC_1234, 2'd2, d, cyc);
        chk(cyc == 1, "R3 hit latency", cyc, 1);
        chk(d == fmodel(rmp(32'h0ABC_1234)), "R3 first hit data", d, fmodel(rmp(32'h0ABC_1234)));
        for (int i = 2; i < 14; i++) begin
            a = 32'h0ABC_1230 + 32'(4 * i);
            bread(a, 2'd2, d, cyc);
            chk(d == fmodel(rmp(a)), "R3 sequential data", d, fmodel(rmp(a)));
        end

        // R7: DMA pacing after a new run
        dma_en = 1'b1;
        bread(32'h0ABC_4000, 2'd2, d, cyc);
        chk(d == fmodel(rmp(32'h0ABC_4000)), "R6 non-sequential data", d, fmodel(rmp(32'h0ABC_4000)));
        idle(2);
        ndma = 0;
        idle(40);
        chk(ndma == 4, "R7 one pulse per prefetched word", ndma, 4);
        for (int i = 1; i < 5; i++) begin
            a = 32'h0ABC_4000 + 32'(4 * i);
            bread(a, 2'd2, d, cyc);
            chk(d == fmodel(rmp(a)), "R7 paced read data", d, fmodel(rmp(a)));
        end
        idle(40);
        chk(ndma == 8, "R7 refill pulses", ndma, 8);
        dma_en = 1'b0;
        bread(32'h0ABC_4014, 2'd2, d, cyc);
        idle(40);
        chk(ndma == 8, "R7 no pulse with dma disabled", ndma, 8);

        // R5: narrow reads, each one direct, no DMA
        dma_en = 1'b1;
        bread(32'h0ABC_5000, 2'd0, d, cyc);
        idle(30);
        ndma = 0;
        for (int o = 0; o < 4; o++) begin
            a = 32'h0ABC_5000 + 32'(o);
            n0 = nreads;
            bread(a, 2'd0, d, cyc);
            idle(10);
            chk(d == exp_lane(fmodel(rmp(a)), a[1:0], 2'd0), "R5 byte lane", d,
                exp_lane(fmodel(rmp(a)), a[1:0], 2'd0));
            chk(nreads - n0 == 1, "R5 single read per byte access", nreads - n0, 1);
        end
        for (int o = 0; o < 4; o += 2) begin
            a = 32'h0ABC_5100 + 32'(o);
            n0 = nreads;
            bread(a, 2'd1, d, cyc);
            idle(10);
            chk(d == exp_lane(fmodel(rmp(a)), a[1:0], 2'd1), "R5 halfword lane", d,
                exp_lane(fmodel(rmp(a)), a[1:0], 2'd1));
            chk(nreads - n0 == 1, "R5 single read per halfword access", nreads - n0, 1);
        end
        chk(ndma == 0, "R5 narrow reads raise no DMA", ndma, 0);

        // R9: disable flushes and idles
        dma_en = 1'b0;
        bread(32'h0ABC_6000, 2'd2, d, cyc);
        idle(40);
        map_en = 1'b0;
        idle(LAT + 4);
        n0 = nreads;
        idle(30);
        chk(nreads == n0, "R9 idle after disable", nreads - n0, 0);
        bread(32'h0ABC_6004, 2'd2, d, cyc);
        chk(d == 32'h0, "R1 zero after disable", d, 32'h0);
        map_en = 1'b1;
        log_n = 0;
        bread(32'h0ABC_6004, 2'd2, d, cyc);
        chk(cyc > 2, "R9 FIFO emptied, direct read after enable", cyc, LAT + 2);
        chk(log_addr[0] == rmp(32'h0ABC_6004), "R9 direct address", log_addr[0], rmp(32'h0ABC_6004));
        chk(d == fmodel(rmp(32'h0ABC_6004)), "R9 data after enable", d, fmodel(rmp(32'h0ABC_6004)));
        idle(30);

        d0 = cs_err;
        chk(d0 == 0, "R8 select low after each acknowledge", d0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule